// File: doc/BRIEF.md
# Dynamic Phase Alignment Selector

This block picks the best of eight sampling phases for one serial receive lane. Each clock cycle it receives eight samples of the incoming data bit, taken at equally spaced phases. It records where the data transitions fall between neighbouring phases. At the end of every evaluation window it selects the phase that sits opposite the busiest boundary, which is the phase farthest from the transitions. The lane logic uses the chosen phase index and the bit sampled at that phase. It also reads a lock flag that marks the first successful acquisition.

No training pattern is needed. Any data stream with enough transitions locks the block, and a stream without transitions never does. After lock the block keeps measuring and may move to a better phase. Hysteresis stops it from toggling between neighbouring phases. A hold input freezes the choice while the measurement continues. The active-low reset clears everything, and the block then has to acquire again.

Top module: `phase_align_sel`

## Requirements
- R1: While reset is low and on release, `phase_sel` is 0 and `locked`, `phase_chg` and `data_bit` are 0.
- R2: A window with fewer than 8 transitions never leads to lock. A constant input, or one that toggles at most once in 10 cycles, stays unlocked with `phase_sel` at 0.
- R3: Lock is declared only at the end of the second of two back-to-back 64-cycle windows. Each of the two must have seen at least 8 transitions, and both must point to the same phase. One qualifying window is not enough.
- R4: Boundary b (0..6) lies between sample bit b and bit b+1. Boundary 7 lies between bit 7 and bit 0 of the next cycle. Each boundary counter saturates at 15. The target phase is (b+4) mod 8 for the boundary b with the highest count. A tie goes to the lowest index.
- R5: `data_bit` equals `samp[phase_sel]` sampled at the previous clock edge.
- R6: After lock the phase moves only when the target is at least 2 positions away, measured around the ring.
- R7: While `hold` is high, `phase_sel` does not change and first lock is deferred. Measurement continues, so a pending lock or move happens at the first window end after `hold` falls.
- R8: Once set, `locked` stays high through later phase changes until reset.
- R9: `phase_chg` is high for exactly one cycle, in the cycle where `phase_sel` takes a new value, and at no other time.
- R10: Reset applied while the block is locked clears `locked` and `phase_sel` at once. Full acquisition (two windows) is then needed again.
- R11: The phase changes only in the cycle after a window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp | input | 8 | Samples of the data bit at phases 0..7 within this cycle |
| hold | input | 1 | Freezes the phase choice while high |
| phase_sel | output | 3 | Currently selected phase index |
| data_bit | output | 1 | Data bit sampled at the selected phase, one cycle delayed |
| locked | output | 1 | Sticky first-lock flag |
| phase_chg | output | 1 | One-cycle pulse on every phase change |

## Verification
The bench places transitions at boundary 7, where the edge spans two cycles. A design that ignored the previous cycle's last sample would never lock on that pattern. It feeds two equally busy boundaries to test the tie rule; a reversed tie rule lands on the mirror phase. Data that is constant or too sparse must not produce a lock, and it catches a design that locks without transitions or after a single window. It shifts the transitions by one position, then by three, to separate a change held back by hysteresis from a real move. Under hold it confirms the phase stays frozen, the lock is deferred, and a missing pulse or a dropped lock flag after a move is caught.

// File: rtl/pas_pkg.sv
package pas_pkg;

  localparam int DEF_NPH       = 8;
  localparam int DEF_WIN       = 64;
  localparam int DEF_CNT_MAX   = 15;
  localparam int DEF_MIN_EDGES = 8;
  localparam int DEF_HYST      = 2;

  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } trk_state_e;

  // shortest distance between two positions on a ring of n
  function automatic int ring_dist(int a, int b, int n);
    int d;
    d = (a >= b) ? (a - b) : (b - a);
    return (d > n - d) ? (n - d) : d;
  endfunction

endpackage

// File: rtl/pas_rst_sync.sv
module pas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok_n = chain_q[STAGES-1];

endmodule

// File: rtl/pas_edge_hist.sv
module pas_edge_hist #(
  parameter int NPH     = 8,
  parameter int CNT_MAX = 15,
  parameter int CW      = 4,
  parameter int TW      = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPH-1:0]          samp,
  input  logic                    clear,
  output logic [NPH-1:0][CW-1:0]  cnt_now,
  output logic [TW-1:0]           total_now
);

  logic [NPH-1:0]         edge_v;
  logic [NPH-1:0][CW-1:0] cnt_q;
  logic [NPH-1:0][CW-1:0] cnt_d;
  logic                   wrap_q;
  logic                   wrap_vld_q;

  // transition detection between neighbouring phases, last one wraps
  always_comb begin
    for (int i = 0; i < NPH - 1; i++) begin
      edge_v[i] = samp[i] ^ samp[i+1];
    end
    edge_v[NPH-1] = wrap_vld_q & (wrap_q ^ samp[0]);
  end

  generate
    for (genvar g = 0; g < NPH; g++) begin : g_bin
      always_comb begin
        if (edge_v[g] && (cnt_q[g] != CW'(CNT_MAX))) cnt_now[g] = cnt_q[g] + 1'b1;
        else                                          cnt_now[g] = cnt_q[g];
        cnt_d[g] = clear ? '0 : cnt_now[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q[g] <= '0;
        else        cnt_q[g] <= cnt_d[g];
      end

      // R4: counters saturate instead of wrapping back to zero
      a_r4_bin_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q[g] == CW'(CNT_MAX)) && !clear) |=> (cnt_q[g] == CW'(CNT_MAX)));
    end
  endgenerate

  always_comb begin
    total_now = '0;
    for (int i = 0; i < NPH; i++) begin
      total_now = total_now + TW'(cnt_now[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q     <= 1'b0;
      wrap_vld_q <= 1'b0;
    end else begin
      wrap_q     <= samp[NPH-1];
      wrap_vld_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pas_window_eval.sv
module pas_window_eval
  import pas_pkg::*;
#(
  parameter int NPH       = 8,
  parameter int PW        = 3,
  parameter int CW        = 4,
  parameter int TW        = 7,
  parameter int WIN       = 64,
  parameter int WW        = 6,
  parameter int MIN_EDGES = 8,
  parameter int HYST      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hold,
  input  logic [NPH-1:0][CW-1:0] cnt_now,
  input  logic [TW-1:0]          total_now,
  output logic                   win_end,
  output logic [PW-1:0]          phase_q,
  output logic                   locked,
  output logic                   phase_chg
);

  logic [WW-1:0] win_cnt_q, win_cnt_d;
  trk_state_e    state_q, state_d;
  logic [PW-1:0] phase_d;
  logic [PW-1:0] cand_q, cand_d;
  logic          cand_vld_q, cand_vld_d;
  logic          chg_q, chg_d;

  logic [PW-1:0] best_idx;
  logic [CW-1:0] best_val;
  logic [PW-1:0] target;
  logic          qualify;
  logic          far_enough;

  assign win_end = (win_cnt_q == WW'(WIN - 1));

  // busiest boundary, strict compare keeps the lowest index on ties
  always_comb begin
    best_idx = '0;
    best_val = cnt_now[0];
    for (int i = 1; i < NPH; i++) begin
      if (cnt_now[i] > best_val) begin
        best_val = cnt_now[i];
        best_idx = PW'(i);
      end
    end
  end

  assign target     = PW'((int'(best_idx) + NPH / 2) % NPH);
  assign qualify    = (total_now >= TW'(MIN_EDGES));
  assign far_enough = (ring_dist(int'(target), int'(phase_q), NPH) >= HYST);

  always_comb begin
    win_cnt_d  = win_end ? '0 : (win_cnt_q + 1'b1);
    state_d    = state_q;
    phase_d    = phase_q;
    cand_d     = cand_q;
    cand_vld_d = cand_vld_q;
    if (win_end) begin
      unique case (state_q)
        ST_ACQ: begin
          if (!qualify) begin
            cand_vld_d = 1'b0;
          end else if (cand_vld_q && (cand_q == target) && !hold) begin
            state_d = ST_TRACK;
            phase_d = target;
          end else begin
            cand_d     = target;
            cand_vld_d = 1'b1;
          end
        end
        ST_TRACK: begin
          if (qualify && !hold && far_enough) phase_d = target;
        end
        default: ;
      endcase
    end
    chg_d = (phase_d != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt_q  <= '0;
      state_q    <= ST_ACQ;
      phase_q    <= '0;
      cand_q     <= '0;
      cand_vld_q <= 1'b0;
      chg_q      <= 1'b0;
    end else begin
      win_cnt_q  <= win_cnt_d;
      state_q    <= state_d;
      phase_q    <= phase_d;
      cand_q     <= cand_d;
      cand_vld_q <= cand_vld_d;
      chg_q      <= chg_d;
    end
  end

  assign locked    = (state_q == ST_TRACK);
  assign phase_chg = chg_q;

  // R7: hold freezes the selected phase
  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(phase_q));

  // R8: lock is sticky
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R9: pulse accompanies every change, and only a change
  a_r9_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> phase_chg);
  a_r9_pulse_has_change: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |-> !$stable(phase_q));

  // R6: tracking moves only across at least HYST positions
  a_r6_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_chg && $past(locked)) |->
      (ring_dist(int'(phase_q), int'($past(phase_q)), NPH) >= HYST));

  // R2: lock needs a window with enough transitions
  a_r2_lock_needs_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(total_now) >= TW'(MIN_EDGES)));

  // R11: changes happen only right after a window end
  a_r11_change_at_window: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |-> $past(win_end));

endmodule

// File: rtl/phase_align_sel.sv
module phase_align_sel
  import pas_pkg::*;
#(
  parameter int NPH       = DEF_NPH,
  parameter int WIN       = DEF_WIN,
  parameter int CNT_MAX   = DEF_CNT_MAX,
  parameter int MIN_EDGES = DEF_MIN_EDGES,
  parameter int HYST      = DEF_HYST
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPH-1:0]           samp,
  input  logic                     hold,
  output logic [$clog2(NPH)-1:0]   phase_sel,
  output logic                     data_bit,
  output logic                     locked,
  output logic                     phase_chg
);

  localparam int PW = $clog2(NPH);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int TW = $clog2(NPH * CNT_MAX + 1);
  localparam int WW = $clog2(WIN);

  logic                   rst_ok_n;
  logic [NPH-1:0][CW-1:0] cnt_now;
  logic [TW-1:0]          total_now;
  logic                   win_end;
  logic [PW-1:0]          phase_q;
  logic                   data_q;

  pas_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  pas_edge_hist #(
    .NPH(NPH), .CNT_MAX(CNT_MAX), .CW(CW), .TW(TW)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .samp      (samp),
    .clear     (win_end),
    .cnt_now   (cnt_now),
    .total_now (total_now)
  );

  pas_window_eval #(
    .NPH(NPH), .PW(PW), .CW(CW), .TW(TW), .WIN(WIN), .WW(WW),
    .MIN_EDGES(MIN_EDGES), .HYST(HYST)
  ) u_eval (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .hold      (hold),
    .cnt_now   (cnt_now),
    .total_now (total_now),
    .win_end   (win_end),
    .phase_q   (phase_q),
    .locked    (locked),
    .phase_chg (phase_chg)
  );

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) data_q <= 1'b0;
    else           data_q <= samp[phase_q];
  end

  assign phase_sel = phase_q;
  assign data_bit  = data_q;

  // R1: outputs are quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_ok_n |-> (!locked && !phase_chg && (phase_sel == '0)));

endmodule

// File: tb/phase_align_sel_tb.sv
`timescale 1ns/1ps
module phase_align_sel_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] samp;
  logic       hold;
  logic [2:0] phase_sel;
  logic       data_bit;
  logic       locked;
  logic       phase_chg;

  int n_chk;
  int n_bad;
  int pulses;
  int pat_mode;   // 0 constant, 1 toggle each cycle, 2 sparse
  int pb;
  int pb2;
  bit alt;
  logic cval;
  logic d_prev;
  logic d_cur;
  int cyc;
  logic exp_d;
  bit exp_ok;

  phase_align_sel u_dut (
    .clk(clk), .rst_n(rst_n), .samp(samp), .hold(hold),
    .phase_sel(phase_sel), .data_bit(data_bit), .locked(locked), .phase_chg(phase_chg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_samp(input int b, input logic old_v, input logic new_v);
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = (i <= b) ? old_v : new_v;
    return s;
  endfunction

  task automatic drive_next();
    int b;
    cyc++;
    d_prev = d_cur;
    case (pat_mode)
      0: samp = {8{cval}};
      1: begin
        d_cur = ~d_cur;
        b = (alt && cyc[0]) ? pb2 : pb;
        samp = mk_samp(b, d_prev, d_cur);
      end
      default: begin
        if (cyc % 10 == 0) d_cur = ~d_cur;
        samp = mk_samp(pb, d_prev, d_cur);
      end
    endcase
  endtask

  task automatic step(input int n, input bit dchk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dchk && exp_ok) chk(data_bit == exp_d, "R5 data_bit", data_bit, exp_d);
      if (phase_chg) pulses++;
      drive_next();
      exp_d  = samp[phase_sel];
      exp_ok = 1'b1;
    end
  endtask

  task automatic do_reset(input bit keep_hold);
    @(negedge clk);
    rst_n  = 1'b0;
    hold   = keep_hold;
    exp_ok = 1'b0;
    #1;
    chk(locked == 1'b0, "R1/R10 locked in reset", locked, 0);
    chk(phase_sel == 3'd0, "R1/R10 phase in reset", phase_sel, 0);
    step(3, 1'b0);
    chk(phase_chg == 1'b0, "R1 pulse in reset", phase_chg, 0);
    chk(data_bit == 1'b0, "R1 data in reset", data_bit, 0);
    rst_n  = 1'b1;
    pulses = 0;
    exp_ok = 1'b0;
  endtask

  task automatic acquire(input int b, input int tgt, input string req);
    pat_mode = 1; pb = b; alt = 1'b0;
    do_reset(1'b0);
    step(120, 1'b0);
    chk(locked == 1'b0, {req, " R3 no lock after one window"}, locked, 0);
    step(20, 1'b0);
    chk(locked == 1'b1, {req, " R3 lock after two windows"}, locked, 1);
    chk(phase_sel == 3'(tgt), {req, " R4 target phase"}, phase_sel, tgt);
  endtask

  task automatic t_reset();
    pat_mode = 0; cval = 1'b0;
    do_reset(1'b0);
    @(negedge clk);
    chk(phase_sel == 3'd0 && !locked, "R1 after release", phase_sel, 0);
  endtask

  task automatic t_no_edges();
    pat_mode = 0; cval = 1'b0;
    do_reset(1'b0);
    step(300, 1'b0);
    chk(locked == 1'b0, "R2 constant zero", locked, 0);
    cval = 1'b1;
    step(300, 1'b0);
    chk(locked == 1'b0, "R2 constant one", locked, 0);
    chk(phase_sel == 3'd0, "R2 phase stays", phase_sel, 0);
    pat_mode = 2; pb = 2;
    step(300, 1'b0);
    chk(locked == 1'b0, "R2 sparse edges", locked, 0);
    chk(pulses == 0, "R2 no pulses", pulses, 0);
  endtask

  task automatic t_acq_and_track();
    acquire(2, 6, "main");
    chk(pulses == 1, "R9 one pulse on first lock", pulses, 1);
    step(30, 1'b1);
    // shift by one boundary: target 7, one away from 6
    pb = 3;
    step(200, 1'b0);
    chk(phase_sel == 3'd6, "R6 small shift ignored", phase_sel, 6);
    chk(pulses == 1, "R6 no pulse on small shift", pulses, 1);
    // shift to boundary 5: target 1, three away
    pb = 5;
    step(140, 1'b0);
    chk(phase_sel == 3'd1, "R6 large shift followed", phase_sel, 1);
    chk(locked == 1'b1, "R8 lock kept across move", locked, 1);
    chk(pulses == 2, "R9 pulse count after move", pulses, 2);
    step(20, 1'b1);
  endtask

  task automatic t_hold_track();
    hold = 1'b1;
    pb = 0;
    step(200, 1'b0);
    chk(phase_sel == 3'd1, "R7 phase frozen", phase_sel, 1);
    chk(pulses == 2, "R7 no pulse under hold", pulses, 2);
    hold = 1'b0;
    step(140, 1'b0);
    chk(phase_sel == 3'd4, "R7 move after release", phase_sel, 4);
    chk(pulses == 3, "R9 pulse after release", pulses, 3);
  endtask

  task automatic t_wrap();
    acquire(7, 3, "wrap");
    step(20, 1'b1);
  endtask

  task automatic t_tie();
    pat_mode = 1; pb = 1; pb2 = 5; alt = 1'b1;
    do_reset(1'b0);
    step(140, 1'b0);
    chk(locked == 1'b1, "R4 tie lock", locked, 1);
    chk(phase_sel == 3'd5, "R4 tie lowest boundary", phase_sel, 5);
    step(20, 1'b1);
    alt = 1'b0;
  endtask

  task automatic t_hold_acq();
    pat_mode = 1; pb = 2; alt = 1'b0;
    do_reset(1'b1);
    step(300, 1'b0);
    chk(locked == 1'b0, "R7 lock deferred", locked, 0);
    chk(phase_sel == 3'd0, "R7 phase frozen in acq", phase_sel, 0);
    hold = 1'b0;
    step(70, 1'b0);
    chk(locked == 1'b1, "R7 lock after release", locked, 1);
    chk(phase_sel == 3'd6, "R7 phase after release", phase_sel, 6);
  endtask

  task automatic t_reset_mid();
    chk(locked == 1'b1, "R10 locked before reset", locked, 1);
    do_reset(1'b0);
    step(120, 1'b0);
    chk(locked == 1'b0, "R10 reacquire needed", locked, 0);
    step(20, 1'b0);
    chk(locked == 1'b1, "R10 relock", locked, 1);
    chk(phase_sel == 3'd6, "R10 relock phase", phase_sel, 6);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; pulses = 0; cyc = 0;
    pat_mode = 0; pb = 0; pb2 = 0; alt = 1'b0; cval = 1'b0;
    d_prev = 1'b0; d_cur = 1'b0; exp_d = 1'b0; exp_ok = 1'b0;
    samp = '0; hold = 1'b0; rst_n = 1'b0;
    t_reset();
    t_no_edges();
    t_acq_and_track();
    t_hold_track();
    t_wrap();
    t_tie();
    t_hold_acq();
    t_reset_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule